// File: doc/BRIEF.md
# Extended-Precision Result Rounding Unit

This block sits at the end of a floating-point datapath. It receives a result that has not yet been rounded. The result is held in the extended container: a sign, a 15-bit biased exponent, a 64-bit mantissa with an explicit integer bit, and guard, round and sticky bits. The block rounds the mantissa at a point that depends on the requested precision. The result always leaves in the extended container. For a single or double target, the mantissa bits below the rounding point are zero.

The rounding precision comes from one of three sources, in priority order:
- A memory-store indicator names the destination format directly, and it overrides everything else.
- If there is no store, a flag marking the reduced-precision multiply and divide operations forces 24-bit rounding. For those operations the exponent is passed on without any range limit.
- Otherwise a two-bit precision field decides. A narrow register target then has its exponent checked against that narrower range. Overflow either saturates or produces infinity, and underflow flushes to zero.

Results are registered and appear one clock after the input strobe.

Top module: `fp_round_unit`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low one clock after a cycle with `in_valid` low. The data outputs belong to that input.
- R2: Precision encoding 00 (extended) rounds at bit 0 of the 64-bit mantissa. The guard bit is `in_grs[2]`, and the round and sticky bits are `in_grs[1:0]`.
- R3: Precision 01 (single) keeps the top 24 mantissa bits and precision 10 (double) keeps the top 53. Every output mantissa bit below the kept field is zero.
- R4: Rounding mode 00 rounds to nearest with ties to even, 01 rounds toward zero, 10 rounds toward minus infinity and 11 rounds toward plus infinity. The decision uses the first dropped bit and the OR of all lower dropped bits.
- R5: When rounding carries out of the mantissa, the output mantissa is 0x8000_0000_0000_0000 and the exponent is one greater.
- R6: `out_inexact` is set when any dropped bit or any of `in_grs` is 1. It is also set whenever overflow or underflow is reported.
- R7: For a narrow register target, a rounded biased exponent above the maximum raises `out_overflow`. The maximum is 0x407E for single and 0x43FE for double. The result is then infinity (exponent 0x7FFF, mantissa 0) for nearest mode and for modes that round away from zero in the sign's direction. For the other modes the result is the largest finite value of that format.
- R8: For a narrow register target, a nonzero result with a biased exponent below the minimum raises `out_underflow` and flushes exponent and mantissa to zero. The minimum is 0x3F81 for single and 0x3C01 for double. A zero result does not underflow.
- R9: With `sgl_op` high and `mem_dst` low, the mantissa is rounded to 24 bits whatever `prec_ctl` holds. The exponent passes through unchecked, and neither overflow nor underflow is raised.
- R10: With `mem_dst` high, `prec_ctl` and `sgl_op` are ignored and `mem_fmt` selects the precision, using the same encoding as `prec_ctl`. An extended `mem_fmt` never raises range flags.
- R11: Precision encoding 11 behaves as extended.
- R12: During and directly after a synchronous reset, `out_valid`, the data outputs and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_sign | input | 1 | Sign of unrounded value |
| in_exp | input | 15 | Biased exponent (bias 16383) |
| in_mant | input | 64 | Mantissa with explicit integer bit at 63 |
| in_grs | input | 3 | Guard, round, sticky bits below mantissa bit 0 |
| prec_ctl | input | 2 | Precision control: 00 ext, 01 single, 10 double, 11 ext |
| rnd_mode | input | 2 | Rounding mode: 00 nearest, 01 zero, 10 minus inf, 11 plus inf |
| sgl_op | input | 1 | Reduced-precision multiply/divide operation |
| mem_dst | input | 1 | Result is bound for memory |
| mem_fmt | input | 2 | Memory destination format, same encoding as `prec_ctl` |
| out_valid | output | 1 | Result strobe |
| out_sign | output | 1 | Result sign |
| out_exp | output | 15 | Result biased exponent |
| out_mant | output | 64 | Rounded mantissa |
| out_inexact | output | 1 | Result differs from the unrounded value |
| out_overflow | output | 1 | Exponent above target range |
| out_underflow | output | 1 | Nonzero result below target range |

## Verification
The rounding logic is tried with three kinds of input patterns:
- Exact ties with an odd and an even kept LSB, which separate ties-to-even from plain round-half-up.
- Sticky-only remainders under the directed modes, with both signs, which show whether the sign steers the increment.
- All-ones kept fields, which drive the carry and renormalise path, once well inside the range and once at its upper edge, where the carry itself causes overflow.

One fixed mantissa with bit 23 set is rounded under single, double, extended and memory-override selections. Only the chosen rounding point decides whether that bit survives, so the precision source is identified. Exponents just inside the narrow limits, and far outside them, separate range checking from the unchecked reduced-precision operations.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  typedef enum logic [1:0] {
    PREC_EXT = 2'b00,
    PREC_SGL = 2'b01,
    PREC_DBL = 2'b10,
    PREC_RSV = 2'b11
  } prec_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_DOWN = 2'b10,
    RM_UP   = 2'b11
  } rmode_e;

  // Increment decision from kept LSB, first dropped bit and the OR below it.
  function automatic logic round_up(input rmode_e m, input logic s,
                                    input logic lsb, input logic g,
                                    input logic st);
    logic r;
    case (m)
      RM_NEAR: r = g & (st | lsb);
      RM_ZERO: r = 1'b0;
      RM_DOWN: r = s & (g | st);
      default: r = ~s & (g | st);
    endcase
    return r;
  endfunction

  // Overflow produces infinity rather than the largest finite value.
  function automatic logic ovf_to_inf(input rmode_e m, input logic s);
    return (m == RM_NEAR) || (m == RM_DOWN && s) || (m == RM_UP && !s);
  endfunction

endpackage

// File: rtl/fpr_prec_select.sv
module fpr_prec_select
  import fpr_pkg::*;
(
  input  logic [1:0] prec_ctl,
  input  logic       sgl_op,
  input  logic       mem_dst,
  input  logic [1:0] mem_fmt,
  output prec_e      eff_prec,
  output logic       range_en
);

  prec_e sel;

  always_comb begin
    if (mem_dst)      sel = prec_e'(mem_fmt);
    else if (sgl_op)  sel = PREC_SGL;
    else              sel = prec_e'(prec_ctl);

    eff_prec = (sel == PREC_RSV) ? PREC_EXT : sel;
    // Reduced-precision operations to a register keep the full exponent.
    range_en = (eff_prec != PREC_EXT) && (mem_dst || !sgl_op);
  end

endmodule

// File: rtl/fpr_mant_round.sv
module fpr_mant_round
  import fpr_pkg::*;
#(
  parameter int MANT_W   = 64,
  parameter int SGL_BITS = 24,
  parameter int DBL_BITS = 53
) (
  input  logic              sign,
  input  logic [MANT_W-1:0] mant,
  input  logic [2:0]        grs,
  input  prec_e             eff_prec,
  input  rmode_e            rmode,
  output logic [MANT_W-1:0] rnd_mant,
  output logic              carry,
  output logic              inexact
);

  localparam int NUM_PREC = 3;

  for (genvar i = 0; i < NUM_PREC; i++) begin : g_prec
    localparam int KEEP = (i == 0) ? MANT_W : ((i == 1) ? SGL_BITS : DBL_BITS);
    localparam int DROP = MANT_W - KEEP;
    localparam logic [MANT_W:0] STEP = (MANT_W + 1)'(1) << DROP;

    logic              guard;
    logic              sticky;
    logic              lsb;
    logic              up;
    logic              inx;
    logic [MANT_W-1:0] trunc;
    logic [MANT_W:0]   sum;

    if (DROP == 0) begin : g_full
      assign guard  = grs[2];
      assign sticky = |grs[1:0];
      assign lsb    = mant[0];
      assign trunc  = mant;
    end else if (DROP == 1) begin : g_one
      assign guard  = mant[0];
      assign sticky = |grs;
      assign lsb    = mant[1];
      assign trunc  = {mant[MANT_W-1:1], 1'b0};
    end else begin : g_many
      assign guard  = mant[DROP-1];
      assign sticky = (|mant[DROP-2:0]) | (|grs);
      assign lsb    = mant[DROP];
      assign trunc  = {mant[MANT_W-1:DROP], {DROP{1'b0}}};
    end

    assign up  = round_up(rmode, sign, lsb, guard, sticky);
    assign sum = {1'b0, trunc} + (up ? STEP : '0);
    assign inx = guard | sticky;
  end

  logic [MANT_W:0] sum_sel;

  always_comb begin
    case (eff_prec)
      PREC_SGL: begin sum_sel = g_prec[1].sum; inexact = g_prec[1].inx; end
      PREC_DBL: begin sum_sel = g_prec[2].sum; inexact = g_prec[2].inx; end
      default:  begin sum_sel = g_prec[0].sum; inexact = g_prec[0].inx; end
    endcase
    carry = sum_sel[MANT_W];
    // On carry-out the kept field wrapped to zero: restore the integer bit.
    rnd_mant = carry ? {1'b1, {(MANT_W-1){1'b0}}} : sum_sel[MANT_W-1:0];
  end

endmodule

// File: rtl/fpr_exp_range.sv
module fpr_exp_range
  import fpr_pkg::*;
#(
  parameter int EXP_W    = 15,
  parameter int MANT_W   = 64,
  parameter int SGL_BITS = 24,
  parameter int DBL_BITS = 53,
  parameter int EXP_BIAS = 16383,
  parameter int SGL_EMAX = 127,
  parameter int DBL_EMAX = 1023
) (
  input  logic              sign,
  input  logic [EXP_W:0]    exp_in,
  input  logic [MANT_W-1:0] mant_in,
  input  prec_e             eff_prec,
  input  logic              range_en,
  input  rmode_e            rmode,
  output logic [EXP_W-1:0]  exp_out,
  output logic [MANT_W-1:0] mant_out,
  output logic              ovf,
  output logic              unf
);

  localparam int SGL_MAX_I = EXP_BIAS + SGL_EMAX;
  localparam int SGL_MIN_I = EXP_BIAS - SGL_EMAX + 1;
  localparam int DBL_MAX_I = EXP_BIAS + DBL_EMAX;
  localparam int DBL_MIN_I = EXP_BIAS - DBL_EMAX + 1;

  localparam logic [EXP_W:0] SGL_MAX = SGL_MAX_I[EXP_W:0];
  localparam logic [EXP_W:0] SGL_MIN = SGL_MIN_I[EXP_W:0];
  localparam logic [EXP_W:0] DBL_MAX = DBL_MAX_I[EXP_W:0];
  localparam logic [EXP_W:0] DBL_MIN = DBL_MIN_I[EXP_W:0];

  localparam logic [MANT_W-1:0] SGL_BIG = {{SGL_BITS{1'b1}}, {(MANT_W-SGL_BITS){1'b0}}};
  localparam logic [MANT_W-1:0] DBL_BIG = {{DBL_BITS{1'b1}}, {(MANT_W-DBL_BITS){1'b0}}};

  logic [EXP_W:0]    emax;
  logic [EXP_W:0]    emin;
  logic [MANT_W-1:0] big;

  always_comb begin
    if (eff_prec == PREC_SGL) begin
      emax = SGL_MAX; emin = SGL_MIN; big = SGL_BIG;
    end else begin
      emax = DBL_MAX; emin = DBL_MIN; big = DBL_BIG;
    end

    exp_out  = exp_in[EXP_W-1:0];
    mant_out = mant_in;
    ovf      = 1'b0;
    unf      = 1'b0;

    if (range_en) begin
      if (exp_in > emax) begin
        ovf = 1'b1;
        if (ovf_to_inf(rmode, sign)) begin
          exp_out  = '1;
          mant_out = '0;
        end else begin
          exp_out  = emax[EXP_W-1:0];
          mant_out = big;
        end
      end else if (exp_in < emin && |mant_in) begin
        unf      = 1'b1;
        exp_out  = '0;
        mant_out = '0;
      end
    end
  end

endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
  import fpr_pkg::*;
#(
  parameter int EXP_W    = 15,
  parameter int MANT_W   = 64,
  parameter int SGL_BITS = 24,
  parameter int DBL_BITS = 53,
  parameter int EXP_BIAS = 16383,
  parameter int SGL_EMAX = 127,
  parameter int DBL_EMAX = 1023
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic [2:0]        in_grs,
  input  logic [1:0]        prec_ctl,
  input  logic [1:0]        rnd_mode,
  input  logic              sgl_op,
  input  logic              mem_dst,
  input  logic [1:0]        mem_fmt,
  output logic              out_valid,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [MANT_W-1:0] out_mant,
  output logic              out_inexact,
  output logic              out_overflow,
  output logic              out_underflow
);

  prec_e             eff_prec;
  logic              range_en;
  rmode_e            rmode;
  logic [MANT_W-1:0] rnd_mant;
  logic              carry;
  logic              rnd_inx;
  logic [EXP_W:0]    exp_adj;
  logic [EXP_W-1:0]  fin_exp;
  logic [MANT_W-1:0] fin_mant;
  logic              ovf;
  logic              unf;

  assign rmode = rmode_e'(rnd_mode);

  fpr_prec_select u_sel (
    .prec_ctl (prec_ctl),
    .sgl_op   (sgl_op),
    .mem_dst  (mem_dst),
    .mem_fmt  (mem_fmt),
    .eff_prec (eff_prec),
    .range_en (range_en)
  );

  fpr_mant_round #(
    .MANT_W   (MANT_W),
    .SGL_BITS (SGL_BITS),
    .DBL_BITS (DBL_BITS)
  ) u_rnd (
    .sign     (in_sign),
    .mant     (in_mant),
    .grs      (in_grs),
    .eff_prec (eff_prec),
    .rmode    (rmode),
    .rnd_mant (rnd_mant),
    .carry    (carry),
    .inexact  (rnd_inx)
  );

  assign exp_adj = {1'b0, in_exp} + {{EXP_W{1'b0}}, carry};

  fpr_exp_range #(
    .EXP_W    (EXP_W),
    .MANT_W   (MANT_W),
    .SGL_BITS (SGL_BITS),
    .DBL_BITS (DBL_BITS),
    .EXP_BIAS (EXP_BIAS),
    .SGL_EMAX (SGL_EMAX),
    .DBL_EMAX (DBL_EMAX)
  ) u_rng (
    .sign     (in_sign),
    .exp_in   (exp_adj),
    .mant_in  (rnd_mant),
    .eff_prec (eff_prec),
    .range_en (range_en),
    .rmode    (rmode),
    .exp_out  (fin_exp),
    .mant_out (fin_mant),
    .ovf      (ovf),
    .unf      (unf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_sign      <= 1'b0;
      out_exp       <= '0;
      out_mant      <= '0;
      out_inexact   <= 1'b0;
      out_overflow  <= 1'b0;
      out_underflow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign      <= in_sign;
        out_exp       <= fin_exp;
        out_mant      <= fin_mant;
        out_inexact   <= rnd_inx | ovf | unf;
        out_overflow  <= ovf;
        out_underflow <= unf;
      end
    end
  end

endmodule

// File: rtl/fp_round_unit_chk.sv
module fp_round_unit_chk #(
  parameter int MANT_W   = 64,
  parameter int SGL_BITS = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              sgl_op,
  input logic              mem_dst,
  input logic [1:0]        mem_fmt,
  input logic              out_valid,
  input logic [MANT_W-1:0] out_mant,
  input logic              out_inexact,
  input logic              out_overflow,
  input logic              out_underflow
);

  localparam int LOW = MANT_W - SGL_BITS;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_overflow && out_underflow)); // R7

  AST_RANGE_INEXACT: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_overflow || out_underflow) |-> out_inexact); // R6

  AST_SGL_OP_NO_RANGE: assert property (@(posedge clk) disable iff (rst)
    in_valid && sgl_op && !mem_dst |=> !out_overflow && !out_underflow); // R9

  AST_SGL_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid && sgl_op && !mem_dst |=> out_mant[LOW-1:0] == '0); // R3

  AST_MEM_EXT_NO_RANGE: assert property (@(posedge clk) disable iff (rst)
    in_valid && mem_dst && mem_fmt == 2'b00 |=> !out_overflow && !out_underflow); // R10

endmodule

bind fp_round_unit fp_round_unit_chk #(
  .MANT_W   (MANT_W),
  .SGL_BITS (SGL_BITS)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .sgl_op        (sgl_op),
  .mem_dst       (mem_dst),
  .mem_fmt       (mem_fmt),
  .out_valid     (out_valid),
  .out_mant      (out_mant),
  .out_inexact   (out_inexact),
  .out_overflow  (out_overflow),
  .out_underflow (out_underflow)
);

// File: tb/fp_round_unit_test.sv
module fp_round_unit_test;

  typedef struct packed {
    logic        sign;
    logic [14:0] exp;
    logic [63:0] mant;
    logic [2:0]  grs;
    logic [1:0]  prec;
    logic [1:0]  rm;
    logic        sgl;
    logic        mem;
    logic [1:0]  mfmt;
    logic [14:0] e_exp;
    logic [63:0] e_mant;
    logic        e_inx;
    logic        e_ovf;
    logic        e_unf;
  } vec_t;

  localparam int NV = 22;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 15'h3FFF, 64'h8000000000000000, 3'b000, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 15'h3FFF, 64'h8000000000000000, 1'b0, 1'b0, 1'b0},
    '{1'b0, 15'h3FFF, 64'h8000000000000001, 3'b100, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 15'h3FFF, 64'h8000000000000002, 1'b1, 1'b0, 1'b0},
    '{1'b0, 15'h3FFF, 64'h8000000000000002, 3'b100, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 15'h3FFF, 64'h8000000000000002, 1'b1, 1'b0, 1'b0},
    '{1'b0, 15'h3FFF, 64'hFFFFFF8000000000, 3'b000, 2'b01, 2'b00, 1'b0, 1'b0, 2'b00, 15'h4000, 64'h8000000000000000, 1'b1, 1'b0, 1'b0},
    '{1'b0, 15'h3FFF, 64'hFFFFFF8000000000, 3'b000, 2'b01, 2'b01, 1'b0, 1'b0, 2'b00, 15'h3FFF, 64'hFFFFFF0000000000, 1'b1, 1'b0, 1'b0},
    '{1'b0, 15'h3FFF, 64'h8000000000000001, 3'b000, 2'b10, 2'b11, 1'b0, 1'b0, 2'b00, 15'h3FFF, 64'h8000000000000800, 1'b1, 1'b0, 1'b0},
    '{1'b0, 15'h3FFF, 64'h8000000000000001, 3'b000, 2'b10, 2'b10, 1'b0, 1'b0, 2'b00, 15'h3FFF, 64'h8000000000000000, 1'b1, 1'b0, 1'b0},
    '{1'b1, 15'h3FFF, 64'h8000000000000001, 3'b000, 2'b10, 2'b10, 1'b0, 1'b0, 2'b00, 15'h3FFF, 64'h8000000000000800, 1'b1, 1'b0, 1'b0},
    '{1'b0, 15'h5000, 64'h8000000000000001, 3'b000, 2'b00, 2'b00, 1'b1, 1'b0, 2'b00, 15'h5000, 64'h8000000000000000, 1'b1, 1'b0, 1'b0},
    '{1'b0, 15'h5000, 64'h8000000000000000, 3'b000, 2'b01, 2'b00, 1'b0, 1'b0, 2'b00, 15'h7FFF, 64'h0000000000000000, 1'b1, 1'b1, 1'b0},
    '{1'b0, 15'h5000, 64'h8000000000000000, 3'b000, 2'b01, 2'b01, 1'b0, 1'b0, 2'b00, 15'h407E, 64'hFFFFFF0000000000, 1'b1, 1'b1, 1'b0},
    '{1'b0, 15'h3000, 64'h8000000000000000, 3'b000, 2'b01, 2'b00, 1'b0, 1'b0, 2'b00, 15'h0000, 64'h0000000000000000, 1'b1, 1'b0, 1'b1},
    '{1'b0, 15'h3FFF, 64'h8000000000800000, 3'b000, 2'b01, 2'b01, 1'b0, 1'b1, 2'b10, 15'h3FFF, 64'h8000000000800000, 1'b0, 1'b0, 1'b0},
    '{1'b0, 15'h5000, 64'h8000000000800000, 3'b000, 2'b01, 2'b01, 1'b1, 1'b1, 2'b00, 15'h5000, 64'h8000000000800000, 1'b0, 1'b0, 1'b0},
    '{1'b0, 15'h3FFF, 64'h8000000000000001, 3'b000, 2'b11, 2'b00, 1'b0, 1'b0, 2'b00, 15'h3FFF, 64'h8000000000000001, 1'b0, 1'b0, 1'b0},
    '{1'b1, 15'h43FF, 64'h8000000000000000, 3'b000, 2'b10, 2'b11, 1'b0, 1'b0, 2'b00, 15'h43FE, 64'hFFFFFFFFFFFFF800, 1'b1, 1'b1, 1'b0},
    '{1'b0, 15'h3F81, 64'h8000000000000000, 3'b000, 2'b01, 2'b00, 1'b0, 1'b0, 2'b00, 15'h3F81, 64'h8000000000000000, 1'b0, 1'b0, 1'b0},
    '{1'b0, 15'h407E, 64'hFFFFFF8000000000, 3'b000, 2'b01, 2'b00, 1'b0, 1'b0, 2'b00, 15'h7FFF, 64'h0000000000000000, 1'b1, 1'b1, 1'b0},
    '{1'b0, 15'h3FFF, 64'h8000000000000000, 3'b001, 2'b00, 2'b01, 1'b0, 1'b0, 2'b00, 15'h3FFF, 64'h8000000000000000, 1'b1, 1'b0, 1'b0},
    '{1'b0, 15'h3FFF, 64'h8000000000000000, 3'b110, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 15'h3FFF, 64'h8000000000000001, 1'b1, 1'b0, 1'b0},
    '{1'b0, 15'h407E, 64'hFFFFFF0000000000, 3'b000, 2'b01, 2'b00, 1'b0, 1'b0, 2'b00, 15'h407E, 64'hFFFFFF0000000000, 1'b0, 1'b0, 1'b0},
    '{1'b0, 15'h0000, 64'h0000000000000000, 3'b000, 2'b01, 2'b00, 1'b0, 1'b0, 2'b00, 15'h0000, 64'h0000000000000000, 1'b0, 1'b0, 1'b0}
  };

  localparam string TAGS [NV] = '{
    "R2", "R4", "R4", "R5", "R3", "R4", "R4", "R4", "R9", "R7", "R7",
    "R8", "R10", "R10", "R11", "R7", "R8", "R5", "R6", "R2", "R7", "R8"
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_sign;
  logic [14:0] in_exp;
  logic [63:0] in_mant;
  logic [2:0]  in_grs;
  logic [1:0]  prec_ctl;
  logic [1:0]  rnd_mode;
  logic        sgl_op;
  logic        mem_dst;
  logic [1:0]  mem_fmt;
  logic        out_valid;
  logic        out_sign;
  logic [14:0] out_exp;
  logic [63:0] out_mant;
  logic        out_inexact;
  logic        out_overflow;
  logic        out_underflow;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fp_round_unit uut (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_sign       (in_sign),
    .in_exp        (in_exp),
    .in_mant       (in_mant),
    .in_grs        (in_grs),
    .prec_ctl      (prec_ctl),
    .rnd_mode      (rnd_mode),
    .sgl_op        (sgl_op),
    .mem_dst       (mem_dst),
    .mem_fmt       (mem_fmt),
    .out_valid     (out_valid),
    .out_sign      (out_sign),
    .out_exp       (out_exp),
    .out_mant      (out_mant),
    .out_inexact   (out_inexact),
    .out_overflow  (out_overflow),
    .out_underflow (out_underflow)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_sign  = v.sign;
    in_exp   = v.exp;
    in_mant  = v.mant;
    in_grs   = v.grs;
    prec_ctl = v.prec;
    rnd_mode = v.rm;
    sgl_op   = v.sgl;
    mem_dst  = v.mem;
    mem_fmt  = v.mfmt;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst      = 1'b1;
    in_valid = 1'b1;
    drive(VECS[1]);
    repeat (3) @(negedge clk);
    // R12: outputs cleared while reset holds, even with a strobe present
    check("R12", "valid", {63'd0, out_valid}, 64'd0);
    check("R12", "exp", {49'd0, out_exp}, 64'd0);
    check("R12", "mant", out_mant, 64'd0);
    check("R12", "flags", {61'd0, out_inexact, out_overflow, out_underflow}, 64'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R12", "valid after reset", {63'd0, out_valid}, 64'd0);
    check("R1", "idle valid", {63'd0, out_valid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R1", "valid", {63'd0, out_valid}, 64'd1);
      check(TAGS[i], "sign", {63'd0, out_sign}, {63'd0, VECS[i].sign});
      check(TAGS[i], "exp", {49'd0, out_exp}, {49'd0, VECS[i].e_exp});
      check(TAGS[i], "mant", out_mant, VECS[i].e_mant);
      check(TAGS[i], "inexact", {63'd0, out_inexact}, {63'd0, VECS[i].e_inx});
      check(TAGS[i], "overflow", {63'd0, out_overflow}, {63'd0, VECS[i].e_ovf});
      check(TAGS[i], "underflow", {63'd0, out_underflow}, {63'd0, VECS[i].e_unf});
    end

    // R1: strobe drops, so valid drops one cycle later
    @(negedge clk);
    check("R1", "valid drop", {63'd0, out_valid}, 64'd0);

    // R3: same mantissa in single precision through the control field loses bit 23
    drive(VECS[12]);
    mem_dst = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3", "single drops low", out_mant, 64'h8000000000000000);
    check("R3", "single inexact", {63'd0, out_inexact}, 64'd1);

    // R10: double memory format, with a reduced-precision operation flagged,
    // keeps bit 23 exactly
    drive(VECS[12]);
    sgl_op = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "mem overrides sgl_op", out_mant, 64'h8000000000800000);

    // R3: double through the control field keeps bit 23
    drive(VECS[12]);
    mem_dst = 1'b0;
    prec_ctl = 2'b10;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3", "double keeps bit 23", out_mant, 64'h8000000000800000);

    // R8: double underflow limit 0x3C01 is in range, 0x3C00 flushes
    drive(VECS[16]);
    prec_ctl = 2'b10;
    in_exp = 15'h3C01;
    in_valid = 1'b1;
    @(negedge clk);
    check("R8", "double min ok", {62'd0, out_underflow, out_overflow}, 64'd0);
    in_exp = 15'h3C00;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", "double below min", {62'd0, out_underflow, out_overflow}, 64'd2);
    check("R8", "double flushed", out_mant, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule